// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block holds the eight 16-bit general-purpose registers of a processor datapath: accumulator, count, data, base, stack pointer, base pointer, source index and destination index. It offers one write port and two independent read ports. Every port carries a 3-bit register code and a byte/word width bit. In word mode the code picks one of the eight registers. In byte mode the code picks one 8-bit half of the first four registers.

A byte write changes only the addressed half and leaves the partner half untouched, so the eight byte registers behave as independent storage. A separate double-width write path loads a 32-bit result in one clock edge, typically the product or quotient-and-remainder of a wide multiply or divide. Its upper word goes to the data register and its lower word to the accumulator.

Reads are combinational from the stored state. Writes take effect on the rising clock edge. An active-low asynchronous reset clears every register. The block has no states or transitions: its only sequential element is the storage itself, built as sixteen half-word lanes that each carry their own write enable.

Top module: `gpr_file`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every register reads zero on both ports in both modes.
- R2: In word mode the codes are 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index. A word write stores all 16 bits of the write data into the selected register.
- R3: A word read on either port returns all 16 bits of the register its own code selects. The two ports are independent of each other.
- R4: In byte mode, codes 0 to 3 address bits 7..0 of the accumulator, count, data and base registers respectively. Codes 4 to 7 address bits 15..8 of the same four registers in the same order. Code bit 2 selects the high half.
- R5: A byte write stores write-data bits 7..0 into the addressed half only. The other half of that register and all other registers keep their values.
- R6: A byte read returns the addressed half in bits 7..0 of the read data, with bits 15..8 driven to zero.
- R7: When the pair write enable is high at a clock edge, bits 31..16 of the pair data go into the data register and bits 15..0 into the accumulator, on that same edge.
- R8: In a cycle with both a pair write and an ordinary write, the pair write wins for the accumulator and the data register, including their byte halves. An ordinary write to any other register in that cycle still takes effect.
- R9: A read of a register that is being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R10: With both write enables low, no register changes, whatever the write data, code and width inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Ordinary write enable |
| wr_byte | input | 1 | Write width: 1 byte, 0 word |
| wr_sel | input | 3 | Write register code |
| wr_data | input | 16 | Write data (bits 7..0 used in byte mode) |
| pair_wr_en | input | 1 | Double-width result write enable |
| pair_wr_data | input | 32 | Double-width result, high word to data register |
| rd_a_byte | input | 1 | Port A width: 1 byte, 0 word |
| rd_a_sel | input | 3 | Port A register code |
| rd_a_data | output | 16 | Port A read data |
| rd_b_byte | input | 1 | Port B width: 1 byte, 0 word |
| rd_b_sel | input | 3 | Port B register code |
| rd_b_data | output | 16 | Port B read data |

## Verification
The bench builds the block with its default word width of 16, so each half is 8 bits wide and all eight byte codes map onto real storage. At this width every byte code aliases a lane of a word register. A behavioural model that keeps plain 16-bit words can therefore show that a half written in byte mode lands in the right lane and that its partner half survives. It can also show the pair write overriding a clashing ordinary write to the accumulator or data register, while an ordinary write to the base register in that same cycle still completes.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int REG_CNT  = 8;
    localparam int SEL_W    = 3;
    localparam int ALIAS_CNT = 4;

    typedef enum logic [SEL_W-1:0] {
        GR_ACC = 3'd0,
        GR_CNT = 3'd1,
        GR_DAT = 3'd2,
        GR_BAS = 3'd3,
        GR_SP  = 3'd4,
        GR_BP  = 3'd5,
        GR_SI  = 3'd6,
        GR_DI  = 3'd7
    } gr_code_e;

endpackage

// File: rtl/gpr_write_decode.sv
module gpr_write_decode
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic                              wr_en,
    input  logic                              wr_byte,
    input  logic [SEL_W-1:0]                  wr_sel,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              pair_wr_en,
    input  logic [2*WORD_W-1:0]               pair_wr_data,
    output logic [REG_CNT-1:0]                lo_we,
    output logic [REG_CNT-1:0]                hi_we,
    output logic [REG_CNT-1:0][HALF_W-1:0]    lo_d,
    output logic [REG_CNT-1:0][HALF_W-1:0]    hi_d
);

    for (genvar i = 0; i < REG_CNT; i++) begin : g_lane
        localparam logic [SEL_W-1:0] WORD_CODE = SEL_W'(i);
        localparam logic [SEL_W-1:0] LO_CODE   = SEL_W'(i % ALIAS_CNT);
        localparam logic [SEL_W-1:0] HI_CODE   = SEL_W'((i % ALIAS_CNT) + ALIAS_CNT);
        localparam bit ALIASED  = (i < ALIAS_CNT);
        localparam bit PAIR_LO  = (i == int'(GR_ACC));
        localparam bit PAIR_HI  = (i == int'(GR_DAT));

        logic ord_lo, ord_hi;

        always_comb begin
            if (wr_byte) begin
                ord_lo = wr_en && ALIASED && (wr_sel == LO_CODE);
                ord_hi = wr_en && ALIASED && (wr_sel == HI_CODE);
            end else begin
                ord_lo = wr_en && (wr_sel == WORD_CODE);
                ord_hi = ord_lo;
            end
        end

        if (PAIR_LO || PAIR_HI) begin : g_pair
            localparam int BASE = PAIR_HI ? WORD_W : 0;
            always_comb begin
                if (pair_wr_en) begin
                    lo_we[i] = 1'b1;
                    hi_we[i] = 1'b1;
                    lo_d[i]  = pair_wr_data[BASE +: HALF_W];
                    hi_d[i]  = pair_wr_data[BASE+HALF_W +: HALF_W];
                end else begin
                    lo_we[i] = ord_lo;
                    hi_we[i] = ord_hi;
                    lo_d[i]  = wr_data[HALF_W-1:0];
                    hi_d[i]  = wr_byte ? wr_data[HALF_W-1:0] : wr_data[WORD_W-1:HALF_W];
                end
            end
        end else begin : g_plain
            always_comb begin
                lo_we[i] = ord_lo;
                hi_we[i] = ord_hi;
                lo_d[i]  = wr_data[HALF_W-1:0];
                hi_d[i]  = wr_byte ? wr_data[HALF_W-1:0] : wr_data[WORD_W-1:HALF_W];
            end
        end
    end

endmodule

// File: rtl/gpr_half_lane.sv
module gpr_half_lane #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [HALF_W-1:0] d,
    output logic [HALF_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [REG_CNT-1:0][WORD_W-1:0] regs,
    input  logic                           rd_byte,
    input  logic [SEL_W-1:0]               rd_sel,
    output logic [WORD_W-1:0]              rd_data
);

    logic [WORD_W-1:0] alias_word;

    always_comb begin
        alias_word = regs[{1'b0, rd_sel[SEL_W-2:0]}];
        if (rd_byte) begin
            rd_data = '0;
            rd_data[HALF_W-1:0] = rd_sel[SEL_W-1] ? alias_word[WORD_W-1:HALF_W]
                                                  : alias_word[HALF_W-1:0];
        end else begin
            rd_data = regs[rd_sel];
        end
    end

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_byte,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 pair_wr_en,
    input  logic [2*WORD_W-1:0]  pair_wr_data,
    input  logic                 rd_a_byte,
    input  logic [SEL_W-1:0]     rd_a_sel,
    output logic [WORD_W-1:0]    rd_a_data,
    input  logic                 rd_b_byte,
    input  logic [SEL_W-1:0]     rd_b_sel,
    output logic [WORD_W-1:0]    rd_b_data
);

    logic [REG_CNT-1:0]             lo_we, hi_we;
    logic [REG_CNT-1:0][HALF_W-1:0] lo_d, hi_d;
    logic [REG_CNT-1:0][WORD_W-1:0] regs;

    gpr_write_decode #(.WORD_W(WORD_W)) u_dec (
        .wr_en        (wr_en),
        .wr_byte      (wr_byte),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .pair_wr_en   (pair_wr_en),
        .pair_wr_data (pair_wr_data),
        .lo_we        (lo_we),
        .hi_we        (hi_we),
        .lo_d         (lo_d),
        .hi_d         (hi_d)
    );

    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
        gpr_half_lane #(.HALF_W(HALF_W)) u_lo (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (lo_we[i]),
            .d     (lo_d[i]),
            .q     (regs[i][HALF_W-1:0])
        );
        gpr_half_lane #(.HALF_W(HALF_W)) u_hi (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (hi_we[i]),
            .d     (hi_d[i]),
            .q     (regs[i][WORD_W-1:HALF_W])
        );
    end

    gpr_read_port #(.WORD_W(WORD_W)) u_rd_a (
        .regs    (regs),
        .rd_byte (rd_a_byte),
        .rd_sel  (rd_a_sel),
        .rd_data (rd_a_data)
    );

    gpr_read_port #(.WORD_W(WORD_W)) u_rd_b (
        .regs    (regs),
        .rd_byte (rd_b_byte),
        .rd_sel  (rd_b_sel),
        .rd_data (rd_b_data)
    );

    // R2: ordinary word write lands whole in the selected register
    a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte && !pair_wr_en)
        |=> regs[$past(wr_sel)] == $past(wr_data));

    // R5: byte write to a low half keeps the high half
    a_r5_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && !wr_sel[SEL_W-1] && !pair_wr_en)
        |=> (regs[$past(wr_sel)][WORD_W-1:HALF_W] == $past(regs[wr_sel][WORD_W-1:HALF_W]))
         && (regs[$past(wr_sel)][HALF_W-1:0] == $past(wr_data[HALF_W-1:0])));

    // R5: byte write to a high half keeps the low half
    a_r5_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_sel[SEL_W-1] && !pair_wr_en)
        |=> (regs[$past({1'b0, wr_sel[SEL_W-2:0]})][HALF_W-1:0]
             == $past(regs[{1'b0, wr_sel[SEL_W-2:0]}][HALF_W-1:0])));

    // R7 / R8: pair write fills data and accumulator regardless of ordinary write
    a_r7_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
        pair_wr_en
        |=> (regs[GR_ACC] == $past(pair_wr_data[WORD_W-1:0]))
         && (regs[GR_DAT] == $past(pair_wr_data[2*WORD_W-1:WORD_W])));

    // R10: no enable, no change
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !pair_wr_en) |=> $stable(regs));

    // R6: byte reads have a zero upper half
    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_byte |-> (rd_a_data[WORD_W-1:HALF_W] == '0));

endmodule

// File: tb/gpr_file_test.sv
module gpr_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_byte = 1'b0, pair_wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] pair_wr_data = '0;
    logic        rd_a_byte = 1'b0, rd_b_byte = 1'b0;
    logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
    logic [15:0] rd_a_data, rd_b_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [15:0] model [8];

    always #10 clk = ~clk;

    gpr_file uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel), .wr_data(wr_data),
        .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data),
        .rd_a_byte(rd_a_byte), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_byte(rd_b_byte), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data)
    );

    function automatic logic [15:0] expect_rd(input logic byte_m, input logic [2:0] sel);
        logic [15:0] w;
        if (!byte_m) return model[sel];
        w = model[{1'b0, sel[1:0]}];
        return sel[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic check(input string tag, input string port, input logic [15:0] got,
                         input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s port %s: actual=%h expected=%h", tag, port, got, exp);
        end
    endtask

    task automatic cyc(input string tag,
                       input logic we, input logic wb, input logic [2:0] ws, input logic [15:0] wd,
                       input logic pe, input logic [31:0] pd,
                       input logic ab, input logic [2:0] as, input logic bb, input logic [2:0] bs);
        @(negedge clk);
        wr_en = we; wr_byte = wb; wr_sel = ws; wr_data = wd;
        pair_wr_en = pe; pair_wr_data = pd;
        rd_a_byte = ab; rd_a_sel = as; rd_b_byte = bb; rd_b_sel = bs;
        #1;
        check(tag, "A", rd_a_data, expect_rd(ab, as));
        check(tag, "B", rd_b_data, expect_rd(bb, bs));
        @(posedge clk);
        if (we) begin
            if (!wb) model[ws] = wd;
            else if (ws[2]) model[{1'b0, ws[1:0]}][15:8] = wd[7:0];
            else model[{1'b0, ws[1:0]}][7:0] = wd[7:0];
        end
        if (pe) begin
            model[0] = pd[15:0];
            model[2] = pd[31:16];
        end
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        // R1: reads during reset
        #15;
        check("R1 in reset", "A", rd_a_data, 16'h0000);
        check("R1 in reset", "B", rd_b_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every code, both modes, after reset
        for (int i = 0; i < 8; i++)
            cyc("R1 after reset", 0, 0, 3'(i), 16'hFFFF, 0, 32'hFFFF_FFFF, 0, 3'(i), 1, 3'(i));
        // R2 / R3: word writes to each register, read on both ports
        for (int i = 0; i < 8; i++)
            cyc("R2 word write", 1, 0, 3'(i), 16'h1111 * 16'(i + 1), 0, '0, 0, 3'(i), 0, 3'((i + 7) % 8));
        for (int i = 0; i < 8; i++)
            cyc("R3 word read", 0, 0, '0, '0, 0, '0, 0, 3'(i), 0, 3'(7 - i));
        // R4 / R6: byte reads of every code
        for (int i = 0; i < 8; i++)
            cyc("R4 R6 byte read", 0, 0, '0, '0, 0, '0, 1, 3'(i), 0, 3'(i % 4));
        // R5: byte write to high half of accumulator, then low half of base
        cyc("R5 high byte write", 1, 1, 3'd4, 16'h77AB, 0, '0, 0, 3'd0, 1, 3'd4);
        cyc("R5 low byte write", 1, 1, 3'd3, 16'h55CD, 0, '0, 0, 3'd0, 1, 3'd4);
        cyc("R5 check", 0, 0, '0, '0, 0, '0, 0, 3'd3, 0, 3'd0);
        // R5: byte write to high half of data register, low half of count
        cyc("R5 data high", 1, 1, 3'd6, 16'h00E1, 0, '0, 0, 3'd2, 1, 3'd6);
        cyc("R5 count low", 1, 1, 3'd1, 16'hFF0F, 0, '0, 0, 3'd2, 0, 3'd1);
        cyc("R5 check 2", 0, 0, '0, '0, 0, '0, 0, 3'd1, 1, 3'd5);
        // R7: pair write
        cyc("R7 pair write", 0, 0, '0, '0, 1, 32'hDEAD_BEEF, 0, 3'd0, 0, 3'd2);
        cyc("R7 check", 0, 0, '0, '0, 0, '0, 0, 3'd0, 0, 3'd2);
        // R8: pair vs ordinary word write to accumulator
        cyc("R8 clash acc", 1, 0, 3'd0, 16'h1234, 1, 32'hCAFE_F00D, 0, 3'd0, 0, 3'd2);
        // R8: pair vs byte write to data high half
        cyc("R8 clash dat byte", 1, 1, 3'd6, 16'h0099, 1, 32'h0102_0304, 0, 3'd0, 0, 3'd2);
        // R8: pair plus byte write to base low half, both apply
        cyc("R8 side write", 1, 1, 3'd3, 16'h0042, 1, 32'hA5A5_5A5A, 0, 3'd0, 0, 3'd3);
        // R8: pair plus word write to stack pointer
        cyc("R8 side word", 1, 0, 3'd4, 16'hBEEF, 1, 32'h1357_2468, 0, 3'd4, 0, 3'd2);
        cyc("R8 check", 0, 0, '0, '0, 0, '0, 0, 3'd4, 0, 3'd3);
        cyc("R8 check 2", 0, 0, '0, '0, 0, '0, 0, 3'd0, 0, 3'd2);
        // R9: same-cycle read of written register returns old value
        cyc("R9 same cycle", 1, 0, 3'd6, 16'h6666, 0, '0, 0, 3'd6, 0, 3'd6);
        cyc("R9 next cycle", 0, 0, '0, '0, 0, '0, 0, 3'd6, 0, 3'd6);
        cyc("R9 byte same cycle", 1, 1, 3'd5, 16'h0033, 0, '0, 1, 3'd5, 0, 3'd1);
        cyc("R9 byte next", 0, 0, '0, '0, 0, '0, 1, 3'd5, 0, 3'd1);
        // R10: disabled write with busy inputs
        for (int i = 0; i < 8; i++)
            cyc("R10 idle", 0, i[0], 3'(i), 16'hFACE, 0, 32'hFFFF_0000, 0, 3'(i), 1, 3'(i));
        // R5/R8/R9 mixed pseudo-random traffic
        for (int i = 0; i < 400; i++)
            cyc("R5 R8 random", 1'($urandom), 1'($urandom), 3'($urandom), 16'($urandom),
                ($urandom % 5) == 0, $urandom,
                1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom));
        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        #1;
        check("R1 re-reset", "A", rd_a_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++)
            cyc("R1 re-reset read", 0, 0, '0, '0, 0, '0, 0, 3'(i), 1, 3'(i));
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule